// File: doc/BRIEF.md
# Graphics Packet Tag Unpacker

This block sits on a stream of 128-bit words that form a graphics interface packet and converts it into register writes for a rendering engine. Every group of data begins with a tag word. The tag holds a loop count, an end-of-packet marker, a data format selector, a descriptor count and a table of sixteen 4-bit register descriptors. The block then consumes the data words that follow. On each one it walks the descriptor table and emits writes of an 8-bit register address and 64-bit data.

Three data formats are handled:
- **Packed:** each 128-bit word carries one register value, and the block reformats it by descriptor.
- **Register list:** each word carries two raw 64-bit values.
- **Image:** words are only counted and forwarded unchanged on a separate raw-word port.

After the last data word of a tag marked as packet end, a one-cycle done pulse is raised and the block waits for the next tag.

Words enter through a valid/ready handshake. Writes, raw words and the done pulse leave from registers one cycle after the word that caused them is accepted.

Top module: `gpkt_unpack`

## Requirements
- R1: Out of reset `in_ready` is 1 and `wr_valid`, `raw_valid`, `pkt_done` and `ad_only` are 0. The tag word is decoded with these fields:
  - loop count: bits 14:0
  - packet end: bit 15
  - format: bits 59:58, where 0 = packed, 1 = register list, 2 or 3 = image
  - descriptor count: bits 63:60
  - descriptor k: bits 64+4k+3 : 64+4k

  Accepting a tag produces no write and no raw word.
- R2: The descriptor index starts at 0 for each tag and advances by one per descriptor consumed. When it reaches the descriptor count it returns to 0 and the loop count drops by one. The tag therefore yields loop count × descriptor count descriptor slots, in table order, repeated for each loop.
- R3: A descriptor count of 0 means all sixteen descriptors are used per loop.
- R4: In packed format, descriptor 0xE writes data bits 63:0 of the word to the address held in bits 71:64. Descriptor 0xF produces no write but still consumes its slot.
- R5: `ad_only` is set when a tag is accepted whose descriptor count is 1 and whose descriptor 0 is 0xE. Otherwise it is cleared at tag acceptance.
- R6: Packed descriptor 1 writes address 0x01 with data {32'b0, byte at 103:96, byte at 71:64, byte at 39:32, byte at 7:0}. The other bits of the word are ignored.
- R7: Packed descriptor 4 writes data {bits 107:100, bits 91:68, bits 47:32, bits 15:0} to address 0x04, or to 0x0C when bit 111 is set. Packed descriptor 5 writes data {bits 95:64, bits 47:32, bits 15:0} to address 0x05, or to 0x0D when bit 111 is set.
- R8: Packed descriptor 3 writes address 0x03 with data {32'b0, 2'b0, bits 45:32, 2'b0, bits 13:0}.
- R9: In register-list format, each word gives two writes. The low half comes first, each half uses one descriptor, and the address is the descriptor value. Descriptors 0xE and 0xF give no write. `in_ready` is 0 for the cycle in which the high half is emitted. If the tag ends on a low half, the high half is dropped.
- R10: In image format, loop-count words are each forwarded unchanged on `raw_word` with `raw_valid`, and no register write is made.
- R11: A tag with loop count 0 consumes no data words. `pkt_done` is a single-cycle pulse, raised together with the last write or raw word of a tag that has packet end set (or one cycle after a zero-loop tag with packet end set). After it, the next accepted word is decoded as a tag.
- R12: In packed format:
  - descriptor 0 writes address 0x00 with data bits 10:0 zero-extended;
  - descriptor 0xA writes address 0x0A with bits 107:100 placed in data bits 63:56 and the rest zero;
  - descriptors 2, 6 to 9, 0xB, 0xC and 0xD write the word's bits 63:0 to an address equal to the descriptor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_word | input | 128 | Tag or data word |
| wr_valid | output | 1 | Register write valid |
| wr_addr | output | 8 | Register write address |
| wr_data | output | 64 | Register write data |
| raw_valid | output | 1 | Image word valid |
| raw_word | output | 128 | Image word forwarded unchanged |
| ad_only | output | 1 | Current tag carries only address+data descriptors |
| pkt_done | output | 1 | One-cycle end-of-packet pulse |

## Verification
The properties assume only that reset is applied before the first word. Beyond that, they assume an accepted word is whatever the upstream presents when `in_valid` and `in_ready` are both high. No ordering of tags and data is assumed, because the sequencer decides what each accepted word means.

The bench drives `in_valid` and `in_word` between clock edges and holds a word until it sees `in_ready` high at the middle of a cycle. This keeps the register-list stall and back-to-back tags within that assumption. It places nonzero filler in the ignored bit ranges so that the field extraction is checked rather than assumed.

// File: rtl/gpkt_pkg.sv
package gpkt_pkg;
   localparam int WORD_W = 128;
   localparam int REG_W  = 64;
   localparam int ADDR_W = 8;
   localparam int DESC_W = 4;
   localparam int NDESC  = 16;
   localparam int LOOP_W = 15;

   typedef enum logic [1:0] {
      FMT_PACKED    = 2'd0,
      FMT_REGLIST   = 2'd1,
      FMT_IMAGE     = 2'd2,
      FMT_IMAGE_ALT = 2'd3
   } fmt_e;

   typedef struct packed {
      logic [LOOP_W-1:0]       loops;
      logic                    last_pkt;
      logic                    pre;
      logic [10:0]             prim;
      fmt_e                    fmt;
      logic [DESC_W-1:0]       nreg;
      logic [NDESC*DESC_W-1:0] descs;
      logic                    ad_only;
   } tag_t;

   localparam logic [DESC_W-1:0] D_PRIM  = 4'h0;
   localparam logic [DESC_W-1:0] D_RGBA  = 4'h1;
   localparam logic [DESC_W-1:0] D_UV    = 4'h3;
   localparam logic [DESC_W-1:0] D_XYZF2 = 4'h4;
   localparam logic [DESC_W-1:0] D_XYZ2  = 4'h5;
   localparam logic [DESC_W-1:0] D_FOG   = 4'hA;
   localparam logic [DESC_W-1:0] D_AD    = 4'hE;
   localparam logic [DESC_W-1:0] D_NOP   = 4'hF;
   localparam logic [ADDR_W-1:0] A_XYZF3 = 8'h0C;
   localparam logic [ADDR_W-1:0] A_XYZ3  = 8'h0D;
endpackage

// File: rtl/gpkt_tag_dec.sv
module gpkt_tag_dec
   import gpkt_pkg::*;
(
   input  logic [WORD_W-1:0] word,
   output tag_t              tag
);
   wire unused_tag_gap = ^word[45:16];

   always_comb begin
      tag.loops    = word[14:0];
      tag.last_pkt = word[15];
      tag.pre      = word[46];
      tag.prim     = word[57:47];
      tag.fmt      = fmt_e'(word[59:58]);
      tag.nreg     = word[63:60];
      tag.descs    = word[127:64];
      tag.ad_only  = (word[63:60] == 4'd1) && (word[67:64] == D_AD);
   end
endmodule

// File: rtl/gpkt_loop_ctr.sv
module gpkt_loop_ctr #(
   parameter int LOOP_W = 15,
   parameter int DESC_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [LOOP_W-1:0] loops_in,
   input  logic [DESC_W-1:0] nreg_in,
   input  logic              step_desc,
   input  logic              step_word,
   output logic [DESC_W-1:0] idx,
   output logic              fin_desc,
   output logic              fin_word
);
   if (LOOP_W < 1 || DESC_W < 1) begin : g_bad_width
      $error("gpkt_loop_ctr: widths must be positive");
   end

   logic [DESC_W-1:0] idx_q, nreg_q;
   logic [LOOP_W-1:0] loops_q;
   logic [DESC_W-1:0] idx_inc;
   logic              wrap;

   assign idx_inc  = idx_q + 1'b1;
   assign wrap     = (idx_inc == nreg_q);
   assign fin_desc = wrap && (loops_q == LOOP_W'(1));
   assign fin_word = (loops_q == LOOP_W'(1));
   assign idx      = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q   <= '0;
         nreg_q  <= '0;
         loops_q <= '0;
      end else if (load) begin
         idx_q   <= '0;
         nreg_q  <= nreg_in;
         loops_q <= loops_in;
      end else if (step_desc) begin
         idx_q <= wrap ? '0 : idx_inc;
         if (wrap) loops_q <= loops_q - 1'b1;
      end else if (step_word) begin
         loops_q <= loops_q - 1'b1;
      end
   end

   assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_desc || step_word) |-> (loops_q != '0));
   assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (nreg_q != '0) |-> (idx_q < nreg_q));
   assert_wrap16_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_desc && !load && nreg_q == '0 && idx_q == '1)
      |=> (idx_q == '0 && loops_q + 1'b1 == $past(loops_q)));
endmodule

// File: rtl/gpkt_packed_fmt.sv
module gpkt_packed_fmt
   import gpkt_pkg::*;
#(
   parameter bit ADC_REDIRECT = 1'b1
) (
   input  logic [DESC_W-1:0] desc,
   input  logic [WORD_W-1:0] word,
   output logic              wr_en,
   output logic [ADDR_W-1:0] addr,
   output logic [REG_W-1:0]  data
);
   logic adc;
   wire  unused_fmt_bits = ^word;

   if (ADC_REDIRECT) begin : g_adc
      assign adc = word[111];
   end else begin : g_no_adc
      assign adc = 1'b0;
   end

   always_comb begin
      wr_en = 1'b1;
      addr  = {4'h0, desc};
      data  = word[63:0];
      case (desc)
         D_PRIM:  data = {53'd0, word[10:0]};
         D_RGBA:  data = {32'd0, word[103:96], word[71:64], word[39:32], word[7:0]};
         D_UV:    data = {32'd0, 2'b00, word[45:32], 2'b00, word[13:0]};
         D_XYZF2: begin
            data = {word[107:100], word[91:68], word[47:32], word[15:0]};
            if (adc) addr = A_XYZF3;
         end
         D_XYZ2: begin
            data = {word[95:64], word[47:32], word[15:0]};
            if (adc) addr = A_XYZ3;
         end
         D_FOG:   data = {word[107:100], 56'd0};
         D_AD:    addr = word[71:64];
         D_NOP:   wr_en = 1'b0;
         default: ;
      endcase
   end
endmodule

// File: rtl/gpkt_unpack.sv
module gpkt_unpack
   import gpkt_pkg::*;
#(
   parameter bit ADC_REDIRECT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_word,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [REG_W-1:0]  wr_data,
   output logic              raw_valid,
   output logic [WORD_W-1:0] raw_word,
   output logic              ad_only,
   output logic              pkt_done
);
   if (WORD_W != 2 * REG_W || NDESC != (1 << DESC_W)) begin : g_bad_shape
      $error("gpkt_unpack: word/descriptor geometry mismatch");
   end

   typedef enum logic [2:0] {ST_TAG, ST_PACK, ST_RLO, ST_RHI, ST_IMG} st_e;

   st_e                     st_q;
   tag_t                    tag_w;
   logic [NDESC*DESC_W-1:0] descs_q;
   logic                    eop_q;
   logic [REG_W-1:0]        hi_q;
   logic [DESC_W-1:0]       idx, desc_cur;
   logic                    fin_desc, fin_word;
   logic                    accept, load, step_desc, step_word;
   logic                    pk_en, rl_en;
   logic [ADDR_W-1:0]       pk_addr;
   logic [REG_W-1:0]        pk_data;
   logic [DESC_W-1:0]       desc_tab [NDESC];

   wire unused_tag_bits = ^{tag_w.pre, tag_w.prim};

   for (genvar g = 0; g < NDESC; g++) begin : g_tab
      assign desc_tab[g] = descs_q[g*DESC_W +: DESC_W];
   end
   assign desc_cur = desc_tab[idx];

   assign in_ready  = (st_q != ST_RHI);
   assign accept    = in_valid && in_ready;
   assign load      = accept && (st_q == ST_TAG);
   assign step_desc = (accept && (st_q == ST_PACK || st_q == ST_RLO)) || (st_q == ST_RHI);
   assign step_word = accept && (st_q == ST_IMG);
   assign rl_en     = (desc_cur != D_AD) && (desc_cur != D_NOP);

   gpkt_tag_dec u_dec (.word(in_word), .tag(tag_w));

   gpkt_loop_ctr #(.LOOP_W(LOOP_W), .DESC_W(DESC_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .load(load), .loops_in(tag_w.loops),
      .nreg_in(tag_w.nreg), .step_desc(step_desc), .step_word(step_word),
      .idx(idx), .fin_desc(fin_desc), .fin_word(fin_word));

   gpkt_packed_fmt #(.ADC_REDIRECT(ADC_REDIRECT)) u_fmt (
      .desc(desc_cur), .word(in_word), .wr_en(pk_en), .addr(pk_addr), .data(pk_data));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_TAG;
         descs_q   <= '0;
         eop_q     <= 1'b0;
         hi_q      <= '0;
         wr_valid  <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
         raw_valid <= 1'b0;
         raw_word  <= '0;
         ad_only   <= 1'b0;
         pkt_done  <= 1'b0;
      end else begin
         wr_valid  <= 1'b0;
         raw_valid <= 1'b0;
         pkt_done  <= 1'b0;
         case (st_q)
            ST_TAG: if (accept) begin
               descs_q <= tag_w.descs;
               eop_q   <= tag_w.last_pkt;
               ad_only <= tag_w.ad_only;
               if (tag_w.loops == '0) begin
                  pkt_done <= tag_w.last_pkt;
               end else begin
                  case (tag_w.fmt)
                     FMT_PACKED:  st_q <= ST_PACK;
                     FMT_REGLIST: st_q <= ST_RLO;
                     default:     st_q <= ST_IMG;
                  endcase
               end
            end
            ST_PACK: if (accept) begin
               wr_valid <= pk_en;
               wr_addr  <= pk_addr;
               wr_data  <= pk_data;
               if (fin_desc) begin
                  st_q     <= ST_TAG;
                  pkt_done <= eop_q;
               end
            end
            ST_RLO: if (accept) begin
               wr_valid <= rl_en;
               wr_addr  <= {4'h0, desc_cur};
               wr_data  <= in_word[REG_W-1:0];
               hi_q     <= in_word[WORD_W-1:REG_W];
               if (fin_desc) begin
                  st_q     <= ST_TAG;
                  pkt_done <= eop_q;
               end else begin
                  st_q <= ST_RHI;
               end
            end
            ST_RHI: begin
               wr_valid <= rl_en;
               wr_addr  <= {4'h0, desc_cur};
               wr_data  <= hi_q;
               if (fin_desc) begin
                  st_q     <= ST_TAG;
                  pkt_done <= eop_q;
               end else begin
                  st_q <= ST_RLO;
               end
            end
            ST_IMG: if (accept) begin
               raw_valid <= 1'b1;
               raw_word  <= in_word;
               if (fin_word) begin
                  st_q     <= ST_TAG;
                  pkt_done <= eop_q;
               end
            end
            default: st_q <= ST_TAG;
         endcase
      end
   end

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_done |=> !pkt_done);
   assert_done_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_done |-> in_ready);
   assert_tag_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_TAG) |=> (!wr_valid && !raw_valid));
   assert_image_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IMG) |=> !wr_valid);
endmodule

// File: tb/test_gpkt_unpack.sv
`timescale 1ns/1ps
module test_gpkt_unpack;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [127:0] in_word = '0;
   logic         in_ready, wr_valid, raw_valid, ad_only, pkt_done;
   logic [7:0]   wr_addr;
   logic [63:0]  wr_data;
   logic [127:0] raw_word;

   int n_chk = 0, n_fail = 0, done_n = 0, done_at = -1;
   logic [71:0]  wq[$];
   logic [127:0] rq[$];

   always #2 clk = ~clk;

   gpkt_unpack i_gpkt_unpack (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_word(in_word), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
      .raw_valid(raw_valid), .raw_word(raw_word), .ad_only(ad_only), .pkt_done(pkt_done));

   always @(negedge clk) begin
      if (wr_valid) wq.push_back({wr_addr, wr_data});
      if (raw_valid) rq.push_back(raw_word);
      if (pkt_done) begin
         done_n++;
         done_at = wq.size() + rq.size();
      end
   end

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic exp_wr(input string req, input int i, input logic [7:0] a, input logic [63:0] d);
      chk(req, (i < wq.size()) ? {56'd0, wq[i]} : {128{1'bx}}, {56'd0, a, d});
   endtask

   task automatic clear();
      wq.delete(); rq.delete(); done_n = 0; done_at = -1;
   endtask

   task automatic send(input logic [127:0] w);
      in_valid = 1'b1;
      in_word  = w;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   function automatic logic [127:0] mk_tag(input int nloop, input bit eop, input logic [1:0] fmt,
                                           input logic [3:0] nreg, input logic [63:0] descs);
      logic [127:0] t = '0;
      t[14:0]   = nloop[14:0];
      t[15]     = eop;
      t[31:20]  = 12'hABC;
      t[57:47]  = 11'h5A5;
      t[59:58]  = fmt;
      t[63:60]  = nreg;
      t[127:64] = descs;
      return t;
   endfunction

   function automatic logic [127:0] ad_word(input logic [7:0] a, input logic [63:0] d);
      logic [127:0] w = '0;
      w[63:0] = d; w[71:64] = a; w[127:72] = {56{1'b1}};
      return w;
   endfunction

   function automatic logic [127:0] xyz_word(input logic [15:0] x, input logic [15:0] y,
                                             input logic [31:0] z, input logic [7:0] f,
                                             input bit adc, input bit full_z);
      logic [127:0] w = '0;
      w[15:0] = x; w[31:16] = 16'hFFFF; w[47:32] = y;
      if (full_z) w[95:64] = z;
      else begin w[91:68] = z[23:0]; w[107:100] = f; w[67:64] = 4'hF; end
      w[111] = adc;
      return w;
   endfunction

   task automatic t_reset();
      chk("R1 in_ready after reset", {127'd0, in_ready}, 128'd1);
      chk("R1 wr_valid after reset", {127'd0, wr_valid}, 128'd0);
      chk("R1 raw_valid after reset", {127'd0, raw_valid}, 128'd0);
      chk("R1 pkt_done after reset", {127'd0, pkt_done}, 128'd0);
      chk("R1 ad_only after reset", {127'd0, ad_only}, 128'd0);
   endtask

   task automatic t_ad_only();
      clear();
      send(mk_tag(2, 1'b1, 2'd0, 4'd1, 64'h0000_0000_0000_000E));
      chk("R5 ad_only set by single A+D tag", {127'd0, ad_only}, 128'd1);
      send(ad_word(8'h4C, 64'h1122_3344_5566_7788));
      send(ad_word(8'h61, 64'hCAFE_0000_BEEF_0001));
      settle();
      chk("R4 A+D write count", wq.size(), 2);
      exp_wr("R4 A+D first", 0, 8'h4C, 64'h1122_3344_5566_7788);
      exp_wr("R4 A+D second", 1, 8'h61, 64'hCAFE_0000_BEEF_0001);
      chk("R11 done count", done_n, 1);
      chk("R11 done with last write", done_at, 2);
   endtask

   task automatic t_packed_mixed();
      logic [127:0] w;
      clear();
      send(mk_tag(1, 1'b0, 2'd0, 4'd6, 64'h0000_0000_00F3_5441));
      w = '0; w[7:0] = 8'h11; w[15:8] = 8'hAA; w[39:32] = 8'h22; w[71:64] = 8'h33; w[103:96] = 8'h44;
      w[127:104] = 24'hFFFFFF;
      send(w);
      send(xyz_word(16'h1234, 16'h5678, 32'h00AB_CDEF, 8'h9A, 1'b0, 1'b0));
      send(xyz_word(16'h0001, 16'h0002, 32'h0000_0003, 8'h04, 1'b1, 1'b0));
      send(xyz_word(16'hAAAA, 16'hBBBB, 32'hDEAD_BEEF, 8'h00, 1'b1, 1'b1));
      w = '0; w[13:0] = 14'h3FFF; w[15:14] = 2'b11; w[45:32] = 14'h1555; w[47:46] = 2'b11;
      send(w);
      send({128{1'b1}});
      settle();
      chk("R11 no done before end tag", done_n, 0);
      send(mk_tag(0, 1'b1, 2'd0, 4'd2, 64'h0000_0000_0000_00EE));
      settle();
      chk("R4 NOP slot gives no write", wq.size(), 5);
      exp_wr("R6 RGBA packing", 0, 8'h01, 64'h0000_0000_4433_2211);
      exp_wr("R7 XYZF2 packing", 1, 8'h04, 64'h9AAB_CDEF_5678_1234);
      exp_wr("R7 XYZF2 ADC redirect", 2, 8'h0C, 64'h0400_0003_0002_0001);
      exp_wr("R7 XYZ2 ADC redirect", 3, 8'h0D, 64'hDEAD_BEEF_BBBB_AAAA);
      exp_wr("R8 UV packing", 4, 8'h03, 64'h0000_0000_1555_3FFF);
      chk("R11 zero-loop end tag pulses done", done_n, 1);
      chk("R11 zero-loop tag consumed no data", done_at, 5);
      chk("R5 ad_only cleared by next tag", {127'd0, ad_only}, 128'd0);
   endtask

   task automatic t_order();
      logic [127:0] w;
      clear();
      send(mk_tag(2, 1'b1, 2'd0, 4'd3, 64'h0000_0000_0000_0A20));
      for (int k = 0; k < 2; k++) begin
         w = {64'h0, 64'hFFFF_F000_0000_0000}; w[10:0] = 11'h100 + 11'(k); w[31:11] = '1;
         send(w);
         send({64'hFFFF_FFFF_FFFF_FFFF, 64'h3F80_0000_4000_0000 + 64'(k)});
         w = '0; w[107:100] = 8'hC0 + 8'(k); w[99:96] = 4'hF; w[63:0] = '1;
         send(w);
      end
      settle();
      chk("R2 write count loops x nreg", wq.size(), 6);
      for (int k = 0; k < 2; k++) begin
         exp_wr("R12 PRIM descriptor", 3*k, 8'h00, 64'h100 + 64'(k));
         exp_wr("R12 raw low-half descriptor", 3*k+1, 8'h02, 64'h3F80_0000_4000_0000 + 64'(k));
         exp_wr("R12 FOG descriptor", 3*k+2, 8'h0A, {8'hC0 + 8'(k), 56'd0});
      end
      chk("R2 done with last slot", done_at, 6);
   endtask

   task automatic t_nreg16();
      clear();
      send(mk_tag(1, 1'b1, 2'd0, 4'd0, 64'hEEEE_EEEE_EEEE_EEEE));
      for (int k = 0; k < 16; k++) send(ad_word(8'h20 + 8'(k), 64'h5000 + 64'(k)));
      settle();
      chk("R3 sixteen writes for count 0", wq.size(), 16);
      exp_wr("R3 first of sixteen", 0, 8'h20, 64'h5000);
      exp_wr("R3 last of sixteen", 15, 8'h2F, 64'h500F);
      chk("R3 done after sixteenth", done_at, 16);
   endtask

   task automatic t_reglist();
      logic [127:0] w0, w1;
      clear();
      w0 = {64'hAAAA_0000_0000_0002, 64'hAAAA_0000_0000_0001};
      w1 = {64'hBBBB_0000_0000_0004, 64'hBBBB_0000_0000_0003};
      send(mk_tag(3, 1'b1, 2'd1, 4'd1, 64'h0000_0000_0000_0006));
      send(w0);
      chk("R9 in_ready low during high half", {127'd0, in_ready}, 128'd0);
      send(w1);
      settle();
      chk("R9 odd count drops last high half", wq.size(), 3);
      exp_wr("R9 low half first", 0, 8'h06, w0[63:0]);
      exp_wr("R9 high half second", 1, 8'h06, w0[127:64]);
      exp_wr("R9 next word low half", 2, 8'h06, w1[63:0]);
      chk("R9 done once", done_n, 1);
      chk("R9 back to tag wait", {127'd0, in_ready}, 128'd1);
      clear();
      send(mk_tag(1, 1'b1, 2'd1, 4'd2, 64'h0000_0000_0000_00F8));
      send(w1);
      settle();
      chk("R9 descriptor F yields no write", wq.size(), 1);
      exp_wr("R9 descriptor as address", 0, 8'h08, w1[63:0]);
      chk("R9 done after high half slot", done_n, 1);
   endtask

   task automatic t_image();
      logic [127:0] iw [3];
      clear();
      iw[0] = {4{32'h0102_0304}}; iw[1] = {4{32'hF0E0_D0C0}}; iw[2] = {128{1'b1}};
      send(mk_tag(3, 1'b1, 2'd2, 4'd1, 64'h0000_0000_0000_000E));
      for (int k = 0; k < 3; k++) send(iw[k]);
      settle();
      chk("R10 raw word count", rq.size(), 3);
      chk("R10 no register writes", wq.size(), 0);
      for (int k = 0; k < 3; k++) chk("R10 raw word unchanged", (k < rq.size()) ? rq[k] : 'x, iw[k]);
      chk("R10 done with last raw word", done_at, 3);
      clear();
      send(mk_tag(1, 1'b1, 2'd3, 4'd1, 64'h0));
      send(iw[1]);
      settle();
      chk("R10 alternate image code", rq.size(), 1);
      chk("R10 alternate image done", done_n, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ad_only();
      t_packed_mixed();
      t_order();
      t_nreg16();
      t_reglist();
      t_image();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule